// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One countdown timer channel with a register port for software. The counter is `CNT_W` bits wide (16 or 32) and loses one count on each tick from the selected tick input. The design does not make the ticks. They come in as single-cycle enables, a fast one and a slow one, and a control bit chooses between them.

A tick that lands while the counter is zero is an underflow. On underflow the counter either reloads from the load register (periodic mode) or wraps to all ones and keeps counting (free mode). Each underflow sets a level interrupt. The interrupt stays set until software writes any value to the acknowledge register.

Software reprograms the channel in three steps. It writes the control register with the enable bit low, which stops the count. It then writes a new load value. Finally it writes control with the enable bit high, which copies the load value into the counter.

Top module: `reload_timer_ch`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The register is picked by `addr_i[3:2]`: 0 is load, 1 is count, 2 is control, 3 is acknowledge. A load write keeps `wdata_i[CNT_W-1:0]`, and the load register reads back zero-extended. The control register keeps only bit 7 (enable), bit 6 (periodic) and bit 3 (fast tick), and reads back those bits with all other bits zero.
- R3: A control write that sets enable while the channel is disabled copies the load value into the counter. No count is taken in that cycle.
- R4: While enabled, the counter decrements once per tick. The tick comes from `tick_fast_i` when bit 3 is 1 and from `tick_slow_i` when bit 3 is 0. The other tick input has no effect.
- R5: In periodic mode (bit 6 = 1), a tick at count zero reloads the counter from the load register.
- R6: In free mode (bit 6 = 0), a tick at count zero wraps the counter to all ones, and counting continues.
- R7: Every underflow sets `irq_o` one cycle later. `irq_o` then stays high until it is acknowledged.
- R8: A write of any data to the acknowledge register clears `irq_o` on the next cycle.
- R9: If an acknowledge write and an underflow fall in the same cycle, `irq_o` stays set.
- R10: A control write with bit 7 = 0 stops the channel, and the counter then holds through any ticks. Writes to the count register are ignored.
- R11: Reading the count register returns the live counter. Reading the acknowledge register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset within the channel |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_fast_i | input | 1 | Fast tick enable, one cycle wide |
| tick_slow_i | input | 1 | Slow tick enable, one cycle wide |
| irq_o | output | 1 | Underflow interrupt, level |

## Verification
The bench builds the channel with `CNT_W = 16`. At that width a free-mode wrap to 0xFFFF, and the loss of the upper load bits on a 32-bit write, can both be seen in a short run. A reference model in the bench follows every cycle of a long random mix of register writes and tick patterns. Small load values keep underflows, reloads and acknowledge collisions frequent in that mix.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_PER_BIT  = 6;
  localparam int unsigned CTRL_FAST_BIT = 3;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ACK   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  load_o,
  output ctrl_t             ctrl_o,
  output logic              arm_o,
  output logic              ack_o
);
  reg_sel_e          sel;
  logic [CNT_W-1:0]  load_q;
  ctrl_t             ctrl_q;
  logic              wr_load, wr_ctrl;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign wr_load = we_i && (sel == SEL_LOAD);
  assign wr_ctrl = we_i && (sel == SEL_CTRL);
  assign ack_o   = we_i && (sel == SEL_ACK);
  // enable edge: only when the channel is currently idle
  assign arm_o   = wr_ctrl && wdata_i[CTRL_EN_BIT] && !ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
    end else if (wr_load) begin
      load_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.en       <= wdata_i[CTRL_EN_BIT];
      ctrl_q.periodic <= wdata_i[CTRL_PER_BIT];
      ctrl_q.fast     <= wdata_i[CTRL_FAST_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_LOAD:  rdata_o[CNT_W-1:0] = load_q;
      SEL_COUNT: rdata_o[CNT_W-1:0] = cnt_i;
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = ctrl_q.en;
        rdata_o[CTRL_PER_BIT]  = ctrl_q.periodic;
        rdata_o[CTRL_FAST_BIT] = ctrl_q.fast;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/timer_tick_sel.sv
module timer_tick_sel
  import rtc_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  logic  tick_fast_i,
  input  logic  tick_slow_i,
  output logic  tick_o
);
  logic raw;
  assign raw    = ctrl_i.fast ? tick_fast_i : tick_slow_i;
  assign tick_o = ctrl_i.en && raw;
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf_o    = tick_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (arm_i) begin
      cnt_q <= load_i;
    end else if (tick_i) begin
      if (at_zero) cnt_q <= periodic_i ? load_i : '1;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // a new underflow wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (uf_i)  irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/reload_timer_ch.sv
module reload_timer_ch
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_fast_i,
  input  logic        tick_slow_i,
  output logic        irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             arm, ack, tick, uf;
  logic             en, periodic;

  assign en       = ctrl_q.en;
  assign periodic = ctrl_q.periodic;

  timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_q),
    .rdata_o (rdata_o),
    .load_o  (load_q),
    .ctrl_o  (ctrl_q),
    .arm_o   (arm),
    .ack_o   (ack)
  );

  timer_tick_sel u_tick (
    .ctrl_i      (ctrl_q),
    .tick_fast_i (tick_fast_i),
    .tick_slow_i (tick_slow_i),
    .tick_o      (tick)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .tick_i     (tick),
    .periodic_i (periodic),
    .load_i     (load_q),
    .cnt_o      (cnt_q),
    .uf_o       (uf)
  );

  timer_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uf_i   (uf),
    .ack_i  (ack),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/timer_ch_checker.sv
module timer_ch_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             periodic,
  input logic             arm,
  input logic             ack,
  input logic             tick,
  input logic             uf,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic             irq
);
  a_r3_arm_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> cnt == $past(load));

  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  a_r5_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0 && periodic) |=> cnt == $past(load));

  a_r6_free_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0 && !periodic) |=> (&cnt));

  a_r10_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !arm) |=> $stable(cnt));

  a_r7_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> irq);

  a_r7_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> $past(uf));

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !uf) |=> !irq);
endmodule

bind reload_timer_ch timer_ch_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (en),
  .periodic (periodic),
  .arm      (arm),
  .ack      (ack),
  .tick     (tick),
  .uf       (uf),
  .cnt      (cnt_q),
  .load     (load_q),
  .irq      (irq_o)
);

// File: tb/reload_timer_ch_tb_top.sv
module reload_timer_ch_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_ACK = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tf = 1'b0, ts = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [CNT_W-1:0] m_load, m_cnt;
  logic m_en, m_per, m_fast, m_irq;

  always #(CLK_P/2) clk = ~clk;

  reload_timer_ch #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_fast_i(tf), .tick_slow_i(ts), .irq_o(irq)
  );

  task automatic m_reset();
    m_load = '0; m_cnt = '0; m_en = 0; m_per = 0; m_fast = 0; m_irq = 0;
  endtask

  task automatic m_step(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic f, input logic s);
    logic tk, uf;
    logic [CNT_W-1:0] nc;
    tk = m_en && (m_fast ? f : s);
    uf = tk && (m_cnt == '0);
    nc = m_cnt;
    if (w && a[3:2] == 2'd2 && d[7] && !m_en) nc = m_load;
    else if (tk) nc = (m_cnt == '0) ? (m_per ? m_load : '1) : m_cnt - 1'b1;
    if (uf) m_irq = 1'b1;
    else if (w && a[3:2] == 2'd3) m_irq = 1'b0;
    if (w && a[3:2] == 2'd0) m_load = d[CNT_W-1:0];
    if (w && a[3:2] == 2'd2) begin m_en = d[7]; m_per = d[6]; m_fast = d[3]; end
    m_cnt = nc;
  endtask

  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic f, input logic s);
    we = w; addr = a; wdata = d; tf = f; ts = s;
    @(posedge clk);
    m_step(w, a, d, f, s);
    @(negedge clk);
    we = 0; tf = 0; ts = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n, input logic fast);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0, fast, !fast);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_reg("R1 load", A_LOAD, 0);
    chk_reg("R1 count", A_CNT, 0);
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 ack", A_ACK, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2: load width and control field positions
    wr(A_LOAD, 32'h0001_2345);
    chk_reg("R2 load mask", A_LOAD, 32'h0000_2345);
    wr(A_CTRL, 32'hFFFF_FF4F);
    chk_reg("R2 ctrl bits", A_CTRL, 32'h0000_0048);
    wr(A_CTRL, 32'h0);

    // R10: count register not writable
    wr(A_LOAD, 32'd5);
    wr(A_CNT, 32'h99);
    chk_reg("R10 count write ignored", A_CNT, 0);

    // R3: arm loads counter
    wr(A_CTRL, 32'hC8);
    chk_reg("R3 arm", A_CNT, 5);

    // R4: tick selection
    ticks(3, 1'b0);
    chk_reg("R4 slow ignored in fast mode", A_CNT, 5);
    ticks(2, 1'b1);
    chk_reg("R4 fast decrements", A_CNT, 3);
    ticks(3, 1'b1);
    chk_reg("R4 reach zero", A_CNT, 0);
    check("R7 no irq before underflow", {31'b0, irq}, 0);

    // R5/R7: periodic reload and interrupt
    ticks(1, 1'b1);
    chk_reg("R5 reload", A_CNT, 5);
    check("R7 irq set", {31'b0, irq}, 1);
    repeat (4) cyc(1'b0, 4'h0, 0, 1'b0, 1'b0);
    check("R7 irq held", {31'b0, irq}, 1);

    // R8/R11
    wr(A_ACK, 32'hDEAD);
    check("R8 ack clears", {31'b0, irq}, 0);
    chk_reg("R11 ack reads zero", A_ACK, 0);
    chk_reg("R11 count live", A_CNT, 5);

    // R9: ack and underflow together
    ticks(5, 1'b1);
    cyc(1'b1, A_ACK, 32'h1, 1'b1, 1'b0);
    check("R9 underflow beats ack", {31'b0, irq}, 1);
    wr(A_ACK, 0);

    // R10: stop holds the counter
    ticks(2, 1'b1);
    wr(A_CTRL, 32'h48);
    chk_reg("R10 stop value", A_CNT, 3);
    ticks(4, 1'b1);
    ticks(4, 1'b0);
    chk_reg("R10 hold", A_CNT, 3);

    // R6: free mode wrap on slow tick
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'h80);
    ticks(2, 1'b1);
    chk_reg("R4 fast ignored in slow mode", A_CNT, 1);
    ticks(2, 1'b0);
    chk_reg("R6 wrap", A_CNT, 32'hFFFF);
    check("R7 irq on free wrap", {31'b0, irq}, 1);
    ticks(1, 1'b0);
    chk_reg("R6 continue", A_CNT, 32'hFFFE);

    // random phase against the model
    rst_n = 1'b0; m_reset();
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic w;
      logic [3:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      w = 1'b0; a = 4'h0; d = $urandom;
      if (r < 10) begin w = 1; a = A_LOAD; d = $urandom_range(0, 12); end
      else if (r < 16) begin w = 1; a = A_CTRL; end
      else if (r < 24) begin w = 1; a = A_ACK; end
      else if (r < 26) begin w = 1; a = A_CNT; end
      cyc(w, a, d, ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 4));
      rd(A_CNT, v);
      check("R4/R5/R6 random count", v, {{(32-CNT_W){1'b0}}, m_cnt});
      check("R7/R8/R9 random irq", {31'b0, irq}, {31'b0, m_irq});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule